// File: doc/BRIEF.md
# Indirect Register Access Window

This block gives a host one 64-bit command/result word as its only route into a small bank of 8-bit controller registers. To start an access, the host writes a command word with the valid flag set. The word also carries an opcode, a direction flag, a 3-bit sub-register selector and a data field. The block decodes the word and drives a one-cycle read or write strobe on a select/strobe bus toward the 8-bit registers. When the access is done, the block clears the valid flag. On a read, it also puts the returned byte into the low data bits.

The host polls the word until the valid flag drops. Completion comes a fixed number of cycles after launch, so the host never waits long. While an access is in flight, the word is locked against new host writes. Opcodes other than the register-access mode, and sub-register codes that name no register, take the same time to complete but produce no bus strobe. A read of this kind returns zero data.

Top module: `cmdwin`

## Requirements
- R1: After reset the command word reads as all zeros and neither strobe is active.
- R2: A host write whose bit 63 (valid) is 0 is stored as given and can be read back unchanged. It launches no access and drives no strobe.
- R3: A host write with bit 63 set, opcode bits [60:57] equal to 6 and a known sub-register code drives exactly one strobe cycle. That cycle is the one right after the write edge. The write strobe is used when bit 56 is 0 and the read strobe when bit 56 is 1. The select equals bits [34:32], and the write byte equals bits [7:0].
- R4: With the default WAIT_CYC of 1, bit 63 still reads 1 in the strobe cycle and in the cycle after it. It reads 0 from the second clock edge after the launching write onward.
- R5: On completion of a read, bits [31:8] read 0 and bits [7:0] hold the byte on ireg_rdata in the final access cycle. Bits [62:32] keep the value the host wrote.
- R6: On completion of a write, the whole word except bit 63 keeps the value the host wrote.
- R7: Host writes made while bit 63 reads 1 are ignored. The word later holds the result of the access in flight.
- R8: An opcode other than 6, or a sub-register code of 5 or 6, gives no strobe. It completes with the same latency as a real access, leaves the registers untouched, and a read of this kind returns 0 in bits [31:0].
- R9: Sub-register codes map as follows: 0 is the own bus address, 1 is data, 2 is control, 4 is the extended address and 7 is soft reset. Code 3 is clock control when written and status when read, and the strobe type alone selects between the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write enable for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Current command/result word |
| ireg_sel | output | 3 | Sub-register select |
| ireg_wr_stb | output | 1 | One-cycle write strobe |
| ireg_rd_stb | output | 1 | One-cycle read strobe |
| ireg_wdata | output | 8 | Byte to be written |
| ireg_rdata | input | 8 | Byte returned by the selected register |

## Verification
The strobe is due in the first cycle after the launching write edge, and the bench samples it at the falling edge of that cycle. The valid flag is due to stay high through one more falling-edge sample and to clear after the second edge. The merged read byte appears at that same point, so each access task checks three consecutive falling edges, each at a fixed position. Every opcode and every sub-register code in both directions is swept this way. The lock-out test holds host writes across both busy edges and then expects the first result at the same third sample.

// File: rtl/cmdwin_pkg.sv
package cmdwin_pkg;
  localparam int CW_W      = 64;
  localparam int BYTE_W    = 8;
  localparam int DATA_W    = 32;
  localparam int SUB_LO    = 32;
  localparam int SUB_W     = 3;
  localparam int RD_BIT    = 56;
  localparam int OP_LO     = 57;
  localparam int OP_W      = 4;
  localparam int VALID_BIT = 63;
  localparam logic [OP_W-1:0] OP_IREG = 4'd6;

  typedef enum logic [1:0] {SQ_IDLE, SQ_STB, SQ_WAIT} seq_st_e;

  function automatic logic [OP_W-1:0] f_op(input logic [CW_W-1:0] w);
    return w[OP_LO +: OP_W];
  endfunction

  function automatic logic [SUB_W-1:0] f_sub(input logic [CW_W-1:0] w);
    return w[SUB_LO +: SUB_W];
  endfunction

  function automatic logic f_sub_known(input logic [SUB_W-1:0] s);
    return (s != 3'd5) && (s != 3'd6);
  endfunction

  function automatic logic [CW_W-1:0] f_complete(input logic [CW_W-1:0] w,
                                                  input logic hit,
                                                  input logic [BYTE_W-1:0] b);
    logic [CW_W-1:0] r;
    r = w;
    r[VALID_BIT] = 1'b0;
    if (w[RD_BIT])
      r[DATA_W-1:0] = hit ? {{(DATA_W-BYTE_W){1'b0}}, b} : '0;
    return r;
  endfunction
endpackage

// File: rtl/cmdwin_decode.sv
module cmdwin_decode
  import cmdwin_pkg::*;
(
  input  logic [CW_W-1:0]  word,
  output logic [SUB_W-1:0] sub,
  output logic             is_rd,
  output logic             hit
);
  always_comb begin
    sub   = f_sub(word);
    is_rd = word[RD_BIT];
    hit   = (f_op(word) == OP_IREG) && f_sub_known(f_sub(word));
  end
endmodule

// File: rtl/cmdwin_seq.sv
module cmdwin_seq
  import cmdwin_pkg::*;
#(
  parameter int WAIT_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic hit,
  input  logic is_rd,
  output logic stb_wr,
  output logic stb_rd,
  output logic done
);
  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (launch) st_q <= SQ_STB;
        SQ_STB: begin
          st_q  <= SQ_WAIT;
          cnt_q <= CNT_W'(WAIT_CYC - 1);
        end
        SQ_WAIT: begin
          if (cnt_q == '0) st_q <= SQ_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    stb_wr = (st_q == SQ_STB) && hit && !is_rd;
    stb_rd = (st_q == SQ_STB) && hit && is_rd;
    done   = (st_q == SQ_WAIT) && (cnt_q == '0);
  end

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb_wr, stb_rd})); // R3
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_wr || stb_rd) |=> !(stb_wr || stb_rd)); // R3
endmodule

// File: rtl/cmdwin.sv
module cmdwin
  import cmdwin_pkg::*;
#(
  parameter int WAIT_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [63:0]       host_wdata,
  output logic [63:0]       host_rdata,
  output logic [2:0]        ireg_sel,
  output logic              ireg_wr_stb,
  output logic              ireg_rd_stb,
  output logic [7:0]        ireg_wdata,
  input  logic [7:0]        ireg_rdata
);
  localparam int BUSY_MAX = WAIT_CYC + 1;
  localparam int BC_W     = $clog2(BUSY_MAX + 2);

  logic [CW_W-1:0]  cmd_q;
  logic             valid, accept, launch, done, hit, is_rd;
  logic [SUB_W-1:0] sub;
  logic [BC_W-1:0]  busy_cnt;

  assign valid  = cmd_q[VALID_BIT];
  assign accept = host_wr && !valid;
  assign launch = accept && host_wdata[VALID_BIT];

  cmdwin_decode u_dec (
    .word (cmd_q), .sub (sub), .is_rd (is_rd), .hit (hit)
  );

  cmdwin_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
    .clk (clk), .rst_n (rst_n), .launch (launch), .hit (hit), .is_rd (is_rd),
    .stb_wr (ireg_wr_stb), .stb_rd (ireg_rd_stb), .done (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      cmd_q <= '0;
    else if (accept) cmd_q <= host_wdata;
    else if (done)   cmd_q <= f_complete(cmd_q, hit, ireg_rdata);
  end

  assign host_rdata = cmd_q;
  assign ireg_sel   = sub;
  assign ireg_wdata = cmd_q[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || !valid) busy_cnt <= '0;
    else if (busy_cnt <= BC_W'(BUSY_MAX)) busy_cnt <= busy_cnt + 1'b1;
  end

  AST_BOUNDED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= BC_W'(BUSY_MAX)); // R4
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !host_rdata[63]); // R4
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && valid && !done) |=> $stable(host_rdata)); // R7
  AST_LAUNCH_STB: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> ((ireg_wr_stb || ireg_rd_stb) ==
                (host_rdata[60:57] == 4'd6 && ireg_sel != 3'd5 && ireg_sel != 3'd6))); // R3
  AST_NO_STB_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (ireg_wr_stb || ireg_rd_stb) |-> (host_rdata[60:57] == 4'd6 && host_rdata[63])); // R8
  AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_rd && !hit) |=> (host_rdata[31:0] == 32'd0)); // R8
endmodule

// File: tb/cmdwin_tb.sv
module cmdwin_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic [2:0]  ireg_sel;
  logic        ireg_wr_stb, ireg_rd_stb;
  logic [7:0]  ireg_wdata, ireg_rdata;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [7:0] dev [8];
  logic [7:0] shadow [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdwin u_dut (
    .clk (clk), .rst_n (rst_n), .host_wr (host_wr), .host_wdata (host_wdata),
    .host_rdata (host_rdata), .ireg_sel (ireg_sel), .ireg_wr_stb (ireg_wr_stb),
    .ireg_rd_stb (ireg_rd_stb), .ireg_wdata (ireg_wdata), .ireg_rdata (ireg_rdata)
  );

  // Register bank model on the strobe bus: code 3 reads back a fixed status.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) dev[i] <= 8'h00;
    end else if (ireg_wr_stb) begin
      if (ireg_sel == 3'd7) for (int i = 0; i < 8; i++) dev[i] <= 8'h00;
      else dev[ireg_sel] <= ireg_wdata;
    end
  end
  assign ireg_rdata = (ireg_sel == 3'd3) ? 8'hF8 : dev[ireg_sel];

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=50000 cycles", cycles);
      summary();
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic rd, input logic [3:0] op,
                                     input logic [2:0] sub, input logic [7:0] d);
    logic [63:0] w = '0;
    w[63] = 1'b1; w[60:57] = op; w[56] = rd; w[49:40] = 10'h155;
    w[34:32] = sub; w[31:0] = {24'hC3C3C3, d};
    return w;
  endfunction

  function automatic logic [63:0] expect_done(input logic [63:0] w);
    logic        legal = (w[60:57] == 4'd6) && (w[34:32] != 3'd5) && (w[34:32] != 3'd6);
    logic [63:0] r = w;
    logic [7:0]  b;
    r[63] = 1'b0;
    if (w[56]) begin
      b = (w[34:32] == 3'd3) ? 8'hF8 : shadow[w[34:32]];
      r[31:0] = legal ? {24'd0, b} : 32'd0;
    end
    return r;
  endfunction

  task automatic access(input logic [63:0] w, input string req);
    logic        legal = (w[60:57] == 4'd6) && (w[34:32] != 3'd5) && (w[34:32] != 3'd6);
    logic        rd = w[56];
    logic [63:0] exp_word;
    @(negedge clk); host_wr = 1'b1; host_wdata = w;
    @(negedge clk); host_wr = 1'b0;
    exp_word = expect_done(w);
    // R3 / R8: strobe cycle right after the write edge
    chk({ireg_wr_stb, ireg_rd_stb} == {legal && !rd, legal && rd},
        {req, " R3 strobe"}, {62'd0, ireg_wr_stb, ireg_rd_stb},
        {62'd0, legal && !rd, legal && rd});
    if (legal) begin
      chk(ireg_sel == w[34:32], {req, " R3 sel"}, 64'(ireg_sel), 64'(w[34:32]));
      if (!rd) chk(ireg_wdata == w[7:0], {req, " R3 wdata"}, 64'(ireg_wdata), 64'(w[7:0]));
    end
    if (legal && !rd) begin
      if (w[34:32] == 3'd7) for (int i = 0; i < 8; i++) shadow[i] = 8'h00;
      else shadow[w[34:32]] = w[7:0];
    end
    @(negedge clk);
    chk(host_rdata[63] && !ireg_wr_stb && !ireg_rd_stb, {req, " R4 still busy"},
        host_rdata, w);
    @(negedge clk);
    chk(host_rdata == exp_word, {req, rd ? " R5 read result" : " R6 write result"},
        host_rdata, exp_word);
  endtask

  initial begin
    logic [63:0] w, w1, w2, exp1;
    for (int i = 0; i < 8; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(host_rdata == 64'd0 && !ireg_wr_stb && !ireg_rd_stb, "R1 reset", host_rdata, 64'd0);
    rst_n = 1'b1;

    // R2: stored without launch
    w = mk(1'b0, 4'd6, 3'd1, 8'h5A); w[63] = 1'b0;
    @(negedge clk); host_wr = 1'b1; host_wdata = w;
    @(negedge clk); host_wr = 1'b0;
    chk(!ireg_wr_stb && !ireg_rd_stb, "R2 no strobe", {62'd0, ireg_wr_stb, ireg_rd_stb}, 64'd0);
    chk(host_rdata == w, "R2 readback", host_rdata, w);
    @(negedge clk);
    chk(host_rdata == w && !ireg_wr_stb, "R2 held", host_rdata, w);

    // R9: write every code, then read every code
    for (int s = 0; s < 5; s++) access(mk(1'b0, 4'd6, 3'(s), 8'(8'h11 * (s + 1))), "R9 write");
    for (int s = 0; s < 8; s++) access(mk(1'b1, 4'd6, 3'(s), 8'h00), "R9 read");
    access(mk(1'b0, 4'd6, 3'd5, 8'h77), "R8 unused sub write");
    access(mk(1'b0, 4'd6, 3'd6, 8'h77), "R8 unused sub write");
    for (int s = 0; s < 5; s++) access(mk(1'b1, 4'd6, 3'(s), 8'h00), "R8 sub no side effect");
    access(mk(1'b0, 4'd6, 3'd7, 8'hFF), "R9 soft reset");
    for (int s = 0; s < 5; s++) access(mk(1'b1, 4'd6, 3'(s), 8'h00), "R9 after soft reset");

    // R8: opcode sweep
    access(mk(1'b0, 4'd6, 3'd1, 8'h3C), "R8 setup");
    for (int op = 0; op < 16; op++) begin
      if (op != 6) begin
        access(mk(1'b0, 4'(op), 3'd1, 8'hA5), "R8 opcode write");
        access(mk(1'b1, 4'(op), 3'd1, 8'h00), "R8 opcode read");
      end
    end
    access(mk(1'b1, 4'd6, 3'd1, 8'h00), "R8 opcode no side effect");

    // R7: writes while busy are ignored
    w1 = mk(1'b1, 4'd6, 3'd1, 8'h00);
    w2 = mk(1'b0, 4'd6, 3'd2, 8'h99);
    exp1 = expect_done(w1);
    @(negedge clk); host_wr = 1'b1; host_wdata = w1;
    @(negedge clk); host_wdata = w2;
    @(negedge clk);
    chk(host_rdata[63] && host_rdata[34:32] == 3'd1, "R7 busy word kept", host_rdata, w1);
    @(negedge clk); host_wr = 1'b0;
    chk(host_rdata == exp1, "R7 first result", host_rdata, exp1);
    access(mk(1'b1, 4'd6, 3'd2, 8'h00), "R7 no write reached register");

    summary();
  end
endmodule